// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed Compare

This block is a purely combinational integer ALU of parameterised width (32 bits by default). It takes two operands and a 3-bit operation selector. It returns a result word and a flag that is high when that word is all zeros. The supported operations are bitwise AND, bitwise OR, addition, subtraction, and a signed less-than test that yields 0 or 1.

Subtraction and the compare share one adder. The second operand is inverted and a carry-in of 1 is applied. The compare reads the sign of the difference corrected by the signed-overflow bit, so the answer stays right when the difference overflows. A branch-on-equal decision subtracts the operands and looks at the zero flag. Selector values that name no operation produce zero.

The block has no state. The usual state-machine layout therefore becomes a decoded operation type, one output process, and a zero detector.

Top module: `int_alu`

## Requirements
- R1: Selector 3'b000 gives result = a AND b, bit by bit.
- R2: Selector 3'b001 gives result = a OR b, bit by bit.
- R3: Selector 3'b010 gives result = (a + b) mod 2^W.
- R4: Selector 3'b110 gives result = (a - b) mod 2^W.
- R5: Selector 3'b111 gives bit 0 = 1 exactly when a < b as two's-complement signed numbers. This holds also when a - b overflows.
- R6: Under selector 3'b111, result bits W-1..1 are zero.
- R7: Selectors 3'b011, 3'b100 and 3'b101 give a result of zero.
- R8: The zero output is 1 exactly when every bit of the result is 0, for every selector.
- R9: Under selector 3'b110, the zero output is 1 exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| op | input | 3 | Operation selector |
| result | output | W | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench runs two instances. A 6-bit instance is swept exhaustively over every operand pair and every selector. In that instance, signed overflow in both directions, the most-negative and most-positive values, and equal operands all occur many times. The sweep therefore separates a true signed compare from a plain sign-of-difference compare and from an unsigned compare. The default 32-bit instance is tried with directed extremes and pseudo-random pairs, which catch carry-chain and width errors that the small instance cannot show. All selectors are applied to every pair, so the undefined selectors and the zero flag are checked on the same data as the defined operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_RSV3 = 3'b011,
        OP_RSV4 = 3'b100,
        OP_RSV5 = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         lt_signed
);
    logic [W-1:0] y_eff;
    logic [W:0]   full;
    logic         ovf;

    always_comb begin
        y_eff     = sub ? ~y : y;
        full      = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
        sum       = full[W-1:0];
        ovf       = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
        lt_signed = sum[W-1] ^ ovf;
    end

    // R5: the corrected sign must agree with an independent signed compare
    always_comb begin
        if (sub) begin
            p_slt_signed_r5: assert ($signed(x) < $signed(y) == lt_signed || $isunknown({x, y}));
        end
    end
endmodule

// File: rtl/int_alu_zero.sv
module int_alu_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);
    always_comb is_zero = ~|val;
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] result,
    output logic         zero
);
    localparam logic [W-1:0] ALL_ZERO = '0;

    alu_op_e      op_q;
    logic         use_sub;
    logic [W-1:0] sum;
    logic         lt;

    always_comb begin
        op_q    = alu_op_e'(op);
        use_sub = (op_q == OP_SUB) || (op_q == OP_SLT);
    end

    int_alu_addsub #(.W(W)) u_addsub (
        .x(a), .y(b), .sub(use_sub), .sum(sum), .lt_signed(lt)
    );

    always_comb begin
        unique case (op_q)
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_ADD:  result = sum;
            OP_SUB:  result = sum;
            OP_SLT:  result = {{(W-1){1'b0}}, lt};
            default: result = ALL_ZERO;
        endcase
    end

    int_alu_zero #(.W(W)) u_zero (.val(result), .is_zero(zero));

    // R6: compare mode leaves upper bits clear
    always_comb begin
        if (op == 3'b111)
            p_slt_upper_r6: assert (result[W-1:1] == '0 || $isunknown({a, b}));
    end
    // R7: reserved selectors give zero
    always_comb begin
        if (op == 3'b011 || op == 3'b100 || op == 3'b101)
            p_rsv_zero_r7: assert (result == '0 && zero);
    end
    // R9: subtraction zero flag equals operand equality
    always_comb begin
        if (op == 3'b110 && !$isunknown({a, b}))
            p_sub_eq_r9: assert (zero == (a == b));
    end
    // R3: addition matches an independent sum
    always_comb begin
        if (op == 3'b010 && !$isunknown({a, b}))
            p_add_r3: assert (result == W'(a + b));
    end
endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
    localparam int WS = 6;
    localparam int WL = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [WS-1:0] sa, sb, sr;
    logic [2:0]    sop, lop;
    logic          sz, lz;
    logic [WL-1:0] la, lb, lr;

    int_alu #(.W(WS)) dut_s (.a(sa), .b(sb), .op(sop), .result(sr), .zero(sz));
    int_alu #(.W(WL)) dut   (.a(la), .b(lb), .op(lop), .result(lr), .zero(lz));

    function automatic longint expect_val(input longint a, input longint b, input int op, input int w);
        longint mask = (64'sd1 <<< w) - 1;
        longint sa_v = (a >= (64'sd1 <<< (w-1))) ? a - (64'sd1 <<< w) : a;
        longint sb_v = (b >= (64'sd1 <<< (w-1))) ? b - (64'sd1 <<< w) : b;
        case (op)
            0: return a & b;
            1: return a | b;
            2: return (a + b) & mask;
            6: return (a - b) & mask;
            7: return (sa_v < sb_v) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            6: return "R4";
            7: return "R5/R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input longint act, input longint exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 20) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint ev;
        longint va[8];
        longint vb[8];
        int seed;
        seed = 11;
        sa = '0; sb = '0; sop = '0; la = '0; lb = '0; lop = '0;
        @(negedge clk);
        // reset-state style check: AND of zeros gives zero, flag set (R1, R8)
        chk(sr, 0, "R1");
        chk(sz, 1, "R8");
        // exhaustive small sweep: R1..R9
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    sa = a[WS-1:0]; sb = b[WS-1:0]; sop = op[2:0];
                    #1;
                    ev = expect_val(a, b, op, WS);
                    chk(sr, ev, req_of(op));
                    chk(sz, (ev == 0) ? 1 : 0, (op == 6) ? "R9" : "R8");
                end
            end
        end
        // wide directed and random pairs
        va[0] = 64'h7FFF_FFFF; vb[0] = 64'h8000_0000;
        va[1] = 64'h8000_0000; vb[1] = 64'h7FFF_FFFF;
        va[2] = 64'hFFFF_FFFF; vb[2] = 64'h0000_0001;
        va[3] = 64'h1234_5678; vb[3] = 64'h1234_5678;
        va[4] = 64'h0;         vb[4] = 64'hFFFF_FFFF;
        for (int i = 5; i < 8; i++) begin
            va[i] = longint'($unsigned($random(seed)));
            vb[i] = longint'($unsigned($random(seed)));
        end
        for (int r = 0; r < 300; r++) begin
            for (int op = 0; op < 8; op++) begin
                longint a64, b64;
                if (r < 8) begin a64 = va[r]; b64 = vb[r]; end
                else begin
                    a64 = longint'($unsigned($random(seed)));
                    b64 = longint'($unsigned($random(seed)));
                end
                la = a64[WL-1:0]; lb = b64[WL-1:0]; lop = op[2:0];
                #1;
                ev = expect_val(longint'(la), longint'(lb), op, WL);
                chk(lr, ev, req_of(op));
                chk(lz, (ev == 0) ? 1 : 0, (op == 6) ? "R9" : "R8");
            end
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule